// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand before it reaches an arithmetic or logic unit. It serves as the second-operand path of a processor datapath. The caller picks one of five operations: logical left, logical right, arithmetic right, rotate right, or rotate right by one through the carry. The shift count comes either from a 5-bit immediate field or from the low byte of a register, and the caller also supplies the current carry flag.

The block returns the shifted value and a carry-out for the flag logic. The carry-out is the last bit that left the operand. Counts of zero, of exactly the data width, and above the data width each have a fixed result. The datapath is combinational. A parameter can add one output register stage, which gives one clock of latency and a synchronous active-low reset.

Top module: `opnd_shifter`

## Requirements
- R1: `shift_kind` encodes the operation as 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, and 4 rotate right with extend. Codes 5 to 7 return `in_value` unchanged, with `carry_in` as the carry-out.
- R2: When `amt_from_reg` is 1, the count is `reg_amt` (0 to 255). When it is 0, the count is `imm_amt` (0 to 31).
- R3: For kinds 0 to 3, a count of zero returns `in_value` unchanged and passes `carry_in` through to the carry-out.
- R4: Logical left by n in 1..31 fills with zeros from bit 0. The carry-out is bit 32-n of the input.
- R5: Logical right by n in 1..31 fills with zeros from bit 31. The carry-out is bit n-1 of the input.
- R6: Arithmetic right by n in 1..31 fills the vacated high bits with copies of input bit 31. The carry-out is bit n-1 of the input.
- R7: Logical left or logical right by exactly 32 gives zero. The carry-out is input bit 0 for left and input bit 31 for right. Either kind with a count above 32 gives zero and a carry-out of 0.
- R8: Arithmetic right by 32 or more sets every result bit to input bit 31. The carry-out is also input bit 31.
- R9: Rotate right with a nonzero count n rotates by n modulo 32. The carry-out is bit ((n-1) mod 32) of the input, which is input bit 31 when n is a multiple of 32.
- R10: Rotate right with extend ignores the count. The result is `{carry_in, in_value[31:1]}` and the carry-out is input bit 0.
- R11: With `REGISTER_OUT`=1, which is the default, `result` and `carry_out` show the value computed from the inputs at the previous rising edge. A clock edge with `rst_n` low clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| in_value | input | 32 | Operand to shift |
| shift_kind | input | 3 | Operation select (see R1) |
| amt_from_reg | input | 1 | 1 selects `reg_amt` as the count, 0 selects `imm_amt` |
| imm_amt | input | 5 | Immediate shift count |
| reg_amt | input | 8 | Low byte of the count register |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Last bit shifted out |

## Verification
Count selection and the operation's own count rule act in the same cycle. The risky cases are the boundary counts 0, 31, 32, 33 and 255, and which count source is active while the other source holds a different value. The bench provokes this directly. It drives the unused source with a contrasting count, including rotate-with-extend cycles where both count inputs are large. It also sets `carry_in` opposite to every bit the shift could produce, so any leak shows at the output. A behavioural model shifts one bit at a time in a loop and predicts each cycle. Its output is compared with `result` and `carry_out` one clock after every input change.

// File: rtl/bshift_pkg.sv
// Package: shared operation encoding for the operand shifter.
// Assumes: the 3-bit encoding is fixed by the instruction decoder.
package bshift_pkg;
    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;
endpackage

// File: rtl/bshift_amt_sel.sv
// Module: bshift_amt_sel
// Picks the shift count from an immediate field or a register byte and
// widens the immediate with zeros.
// Assumes: IMM_W <= AMT_W.
module bshift_amt_sel #(
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  logic             from_reg,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    output logic [AMT_W-1:0] amt
);
    localparam int PAD_W = AMT_W - IMM_W;

    // Select the count source.
    always_comb begin
        if (from_reg) amt = reg_amt;
        else          amt = {{PAD_W{1'b0}}, imm_amt};
    end
endmodule

// File: rtl/bshift_fill_shr.sv
// Module: bshift_fill_shr
// Logarithmic right shifter with a programmable fill bit. The caller places
// a guard bit below the operand. After the shift, bit 0 holds the last bit
// shifted out, or the guard itself when the count is zero.
// Assumes: the count is unsigned; stages whose step reaches W fill the vector.
module bshift_fill_shr #(
    parameter int W     = 33,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     vin,
    input  logic             fill,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     vout
);
    logic [W-1:0] stage [0:AMT_W];

    assign stage[0] = vin;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP >= W) begin : g_full
            // Step covers the whole vector: everything becomes fill.
            assign stage[k+1] = amt[k] ? {W{fill}} : stage[k];
        end else begin : g_part
            // Shift right by STEP, filling from the top.
            assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]}
                                       : stage[k];
        end
    end

    assign vout = stage[AMT_W];
endmodule

// File: rtl/bshift_rotr.sv
// Module: bshift_rotr
// Logarithmic right rotator. The count is taken modulo W through its low bits.
// Assumes: W is a power of two.
module bshift_rotr #(
    parameter int W  = 32,
    parameter int RW = $clog2(W)
) (
    input  logic [W-1:0]  vin,
    input  logic [RW-1:0] amt,
    output logic [W-1:0]  vout
);
    logic [W-1:0] stage [0:RW];

    assign stage[0] = vin;

    for (genvar k = 0; k < RW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        // Rotate right by STEP when this count bit is set.
        assign stage[k+1] = amt[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
                                   : stage[k];
    end

    assign vout = stage[RW];
endmodule

// File: rtl/opnd_shifter.sv
// Module: opnd_shifter
// Second-operand shifter. Left shifts use the right shifter on the
// bit-reversed operand. The carry_in guard bit yields the carry-out for every
// count, including zero. An optional output register adds one clock of latency.
// Assumes: DATA_W is a power of two and AMT_W is large enough to hold DATA_W+1.
module opnd_shifter #(
    parameter int DATA_W       = 32,
    parameter int IMM_W        = 5,
    parameter int AMT_W        = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_value,
    input  logic [2:0]        shift_kind,
    input  logic              amt_from_reg,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic [AMT_W-1:0]  reg_amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    import bshift_pkg::*;

    localparam int RW  = $clog2(DATA_W);
    localparam int EXW = DATA_W + 1;

    shift_kind_e       kind;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_back;
    logic [EXW-1:0]    shr_out;
    logic [EXW-1:0]    shl_out;
    logic [DATA_W-1:0] rot_out;
    logic              shr_fill;
    logic [DATA_W-1:0] comb_res;
    logic              comb_c;

    assign kind = shift_kind_e'(shift_kind);

    bshift_amt_sel #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
        .from_reg (amt_from_reg),
        .imm_amt  (imm_amt),
        .reg_amt  (reg_amt),
        .amt      (amt)
    );

    // Bit reversal of the operand going in, and of the left-shift result coming out.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]   = in_value[DATA_W-1-i];
        assign rev_back[i] = shl_out[DATA_W-i];
    end

    assign shr_fill = (kind == SK_ASR) ? in_value[DATA_W-1] : 1'b0;

    bshift_fill_shr #(.W(EXW), .AMT_W(AMT_W)) u_shr (
        .vin  ({in_value, carry_in}),
        .fill (shr_fill),
        .amt  (amt),
        .vout (shr_out)
    );

    bshift_fill_shr #(.W(EXW), .AMT_W(AMT_W)) u_shl (
        .vin  ({rev_in, carry_in}),
        .fill (1'b0),
        .amt  (amt),
        .vout (shl_out)
    );

    bshift_rotr #(.W(DATA_W), .RW(RW)) u_rot (
        .vin  (in_value),
        .amt  (amt[RW-1:0]),
        .vout (rot_out)
    );

    // Route the chosen operation to the result and carry.
    always_comb begin
        comb_res = in_value;
        comb_c   = carry_in;
        case (kind)
            SK_LSL: begin
                comb_res = rev_back;
                comb_c   = shl_out[0];
            end
            SK_LSR, SK_ASR: begin
                comb_res = shr_out[EXW-1:1];
                comb_c   = shr_out[0];
            end
            SK_ROR: begin
                if (amt != '0) begin
                    comb_res = rot_out;
                    comb_c   = rot_out[DATA_W-1];
                end
            end
            SK_RRX: begin
                comb_res = {carry_in, in_value[DATA_W-1:1]};
                comb_c   = in_value[0];
            end
            default: begin
                comb_res = in_value;
                comb_c   = carry_in;
            end
        endcase
    end

    if (REGISTER_OUT) begin : g_reg
        // Output stage: capture the shifter result each clock, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                carry_out <= 1'b0;
            end else begin
                result    <= comb_res;
                carry_out <= comb_c;
            end
        end
    end else begin : g_comb
        assign result    = comb_res;
        assign carry_out = comb_c;
    end

    // R3
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amt == '0 && kind inside {SK_LSL, SK_LSR, SK_ASR, SK_ROR})
        |-> (comb_res == in_value && comb_c == carry_in));

    // R7
    far_logic_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind inside {SK_LSL, SK_LSR} && int'(amt) > DATA_W)
        |-> (comb_res == '0 && !comb_c));

    // R8
    asr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_ASR && int'(amt) >= DATA_W)
        |-> (comb_res == {DATA_W{in_value[DATA_W-1]}} && comb_c == in_value[DATA_W-1]));

    // R9
    ror_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_ROR && amt != '0) |-> (comb_c == comb_res[DATA_W-1]));

    // R10
    rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_RRX)
        |-> (comb_c == in_value[0] && comb_res[DATA_W-1] == carry_in
             && comb_res[DATA_W-2:0] == in_value[DATA_W-1:1]));
endmodule

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_value = '0;
    logic [2:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  imm_amt = '0;
    logic [7:0]  reg_amt = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] q_r[$];
    logic        q_c[$];
    string       q_t[$];

    always #5 clk = ~clk;

    opnd_shifter u_opnd_shifter (
        .clk(clk), .rst_n(rst_n), .in_value(in_value), .shift_kind(shift_kind),
        .amt_from_reg(amt_from_reg), .imm_amt(imm_amt), .reg_amt(reg_amt),
        .carry_in(carry_in), .result(result), .carry_out(carry_out)
    );

    // Behavioural model: one bit per loop step.
    function automatic void model(input logic [31:0] v, input logic [2:0] k,
                                  input int n, input logic ci,
                                  output logic [31:0] r, output logic co);
        r = v; co = ci;
        case (k)
            3'd0: for (int i = 0; i < n; i++) begin co = r[31]; r = r << 1; end
            3'd1: for (int i = 0; i < n; i++) begin co = r[0]; r = r >> 1; end
            3'd2: for (int i = 0; i < n; i++) begin co = r[0]; r = {r[31], r[31:1]}; end
            3'd3: for (int i = 0; i < n; i++) begin co = r[0]; r = {r[0], r[31:1]}; end
            3'd4: begin co = v[0]; r = {ci, v[31:1]}; end
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] k, input int n, input logic sel);
        string s;
        if (k > 3'd4) return "R1";
        if (k == 3'd4) return "R10";
        s = sel ? "R2/" : "";
        if (n == 0) return {s, "R3"};
        case (k)
            3'd0: return {s, (n < 32) ? "R4" : "R7"};
            3'd1: return {s, (n < 32) ? "R5" : "R7"};
            3'd2: return {s, (n < 32) ? "R6" : "R8"};
            default: return {s, "R9"};
        endcase
    endfunction

    task automatic check_pending();
        logic [31:0] er; logic ec; string t;
        if (q_r.size() == 0) return;
        er = q_r.pop_front(); ec = q_c.pop_front(); t = q_t.pop_front();
        tests++;
        if (result !== er || carry_out !== ec) begin
            fails++;
            $display("FAIL %s/R11: got %h c%b expected %h c%b", t, result, carry_out, er, ec);
        end
    endtask

    task automatic apply(input logic [31:0] v, input logic [2:0] k, input logic sel,
                         input logic [4:0] imm, input logic [7:0] ra, input logic ci,
                         input string t);
        logic [31:0] er; logic ec; int n;
        @(negedge clk);
        check_pending();
        in_value = v; shift_kind = k; amt_from_reg = sel;
        imm_amt = imm; reg_amt = ra; carry_in = ci;
        n = sel ? int'(ra) : int'(imm);
        model(v, k, n, ci, er, ec);
        q_r.push_back(er); q_c.push_back(ec);
        q_t.push_back(t.len() != 0 ? t : tag_of(k, n, sel));
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset clears the output stage while the inputs are busy.
        in_value = 32'hFFFF_FFFF; carry_in = 1'b1; shift_kind = 3'd4;
        repeat (3) @(negedge clk);
        tests++;
        if (result !== '0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: got %h c%b expected 0 c0", result, carry_out);
        end
        rst_n = 1'b1;

        // R1 pass-through codes
        apply(32'h1234_5678, 3'd5, 0, 5'd7, 8'd0, 1'b1, "R1");
        apply(32'h8765_4321, 3'd7, 1, 5'd0, 8'd40, 1'b0, "R1");
        // R3 zero count with the other source nonzero
        apply(32'hA5A5_5A5A, 3'd0, 0, 5'd0, 8'd9, 1'b1, "R3");
        apply(32'hA5A5_5A5A, 3'd3, 1, 5'd17, 8'd0, 1'b0, "R3");
        apply(32'h8000_0001, 3'd2, 1, 5'd3, 8'd0, 1'b1, "R3");
        // R4 / R5 / R6 inner counts
        apply(32'h8000_0001, 3'd0, 0, 5'd1, 8'd0, 1'b0, "R4");
        apply(32'h0000_0003, 3'd0, 0, 5'd31, 8'd0, 1'b1, "R4");
        apply(32'h8000_0001, 3'd1, 0, 5'd1, 8'd0, 1'b0, "R5");
        apply(32'hC000_0000, 3'd1, 0, 5'd31, 8'd0, 1'b0, "R5");
        apply(32'h8000_0010, 3'd2, 0, 5'd4, 8'd0, 1'b0, "R6");
        apply(32'h7FFF_FFFF, 3'd2, 0, 5'd31, 8'd0, 1'b1, "R6");
        // R2 register source chosen over the immediate
        apply(32'h0000_00F0, 3'd1, 1, 5'd31, 8'd4, 1'b0, "R2");
        // R7 boundaries
        apply(32'h0000_0001, 3'd0, 1, 5'd0, 8'd32, 1'b0, "R7");
        apply(32'h8000_0000, 3'd1, 1, 5'd0, 8'd32, 1'b0, "R7");
        apply(32'hFFFF_FFFF, 3'd0, 1, 5'd0, 8'd33, 1'b1, "R7");
        apply(32'hFFFF_FFFF, 3'd1, 1, 5'd0, 8'd255, 1'b1, "R7");
        // R8 saturation
        apply(32'h8000_0000, 3'd2, 1, 5'd0, 8'd32, 1'b0, "R8");
        apply(32'h7FFF_FFFF, 3'd2, 1, 5'd0, 8'd200, 1'b1, "R8");
        // R9 modulo rotate
        apply(32'h8000_0001, 3'd3, 1, 5'd0, 8'd32, 1'b0, "R9");
        apply(32'h0000_0002, 3'd3, 1, 5'd0, 8'd33, 1'b0, "R9");
        apply(32'h0000_0001, 3'd3, 0, 5'd31, 8'd0, 1'b0, "R9");
        // R10 ignores large counts
        apply(32'h0000_0001, 3'd4, 1, 5'd31, 8'd255, 1'b0, "R10");
        apply(32'hFFFF_FFFE, 3'd4, 0, 5'd0, 8'd0, 1'b1, "R10");

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] ra;
            case ($urandom_range(0, 5))
                0: ra = 8'd0;  1: ra = 8'd31; 2: ra = 8'd32;
                3: ra = 8'd33; 4: ra = 8'd64; default: ra = 8'($urandom);
            endcase
            apply($urandom, 3'($urandom_range(0, 7)), 1'($urandom), 5'($urandom),
                  ra, 1'($urandom), "");
        end
        @(negedge clk);
        check_pending();
        finish_run();
    end
endmodule